// File: doc/BRIEF.md
# Page-Mode Burst Sequencer for Pseudo-Static Memory

This block runs a burst of 1 to 16 word accesses inside a single 16-word page of an asynchronous-interface pseudo-static memory. The host issues a start request with a word address, a word count and a direction. It then supplies write words or takes read words one at a time over valid/ready handshakes. The sequencer holds the page bits of the address fixed and steps the four in-page bits once per word. It keeps chip select and both byte enables low for the whole burst. The first word gets the long random-access wait, and every later word gets the short page wait.

A request that would run past the last word of the page is refused with a one-cycle error pulse, and the memory pins stay idle. The memory limits how long chip select may stay low during a burst. If the host stalls long enough to approach that limit, the sequencer ends the burst at a word boundary. It raises a truncation flag and reports how many words were completed.

Top module: `psb_page_burst`

## Requirements
- R1: After synchronous reset, chip select, output enable, write enable and both byte enables are high (inactive), the data drive enable is low, and the start request is ready.
- R2: A start request whose 5-bit count is 0, or whose in-page offset (address bits 3..0) plus count exceeds 16, produces a one-cycle error pulse with no memory strobe and no done pulse.
- R3: During a burst, address bits 20..4 never change, and each address change increments bits 3..0 by exactly one, starting from the requested offset.
- R4: Chip select and both byte enables are held low from burst start to burst end, and all strobes go inactive in the same cycle as the one-cycle done pulse.
- R5: A read word is captured no sooner than FIRST_CYC cycles after the first address is presented, and no sooner than PAGE_CYC cycles after each later address change.
- R6: Read words are returned in address order; while read valid is high and ready is low, the word stays stable until it is taken or the burst is cut short.
- R7: In a write burst, write enable falls exactly once per word, and the word is driven unchanged from the falling edge through the rising edge. Write enable then stays high for at least REC_CYC cycles before the next word.
- R8: Output enable is low only in read bursts, and the memory data bus is never driven while output enable is low.
- R9: Chip select never stays low for LIMIT_CYC cycles. A host stall that nears this limit ends the burst with truncated=1 and words_done equal to the words fully completed.
- R10: A burst that completes normally reports truncated=0 and words_done equal to the requested count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Burst request valid |
| start_ready | output | 1 | Sequencer idle, request accepted |
| start_addr | input | AW | Word address of first access |
| start_cnt | input | PW+1 | Word count, 1 to 16 |
| start_write | input | 1 | 1 = write burst, 0 = read burst |
| wr_valid | input | 1 | Write word valid |
| wr_ready | output | 1 | Write word accepted |
| wr_data | input | DW | Write word |
| rd_valid | output | 1 | Read word valid |
| rd_ready | input | 1 | Host takes read word |
| rd_data | output | DW | Read word |
| done | output | 1 | One-cycle burst end pulse |
| truncated | output | 1 | Last burst ended early |
| words_done | output | PW+1 | Words completed in last burst |
| err | output | 1 | One-cycle range rejection pulse |
| mem_addr | output | AW | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | DW/8 | Byte enables, active low |
| mem_dq_out | output | DW | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DW | Data from memory |

## Verification
The properties assume the host never asks for more than one burst at a time and holds its request until it is accepted. They also assume the memory returns data only through mem_dq_in. The stimulus keeps to this by waiting for each done pulse before the next request. A memory model in the bench returns a poison word whenever the sequencer samples before the access or page wait has elapsed. Stalls are made by withholding write words or read ready for much longer than the window, so the early-end path is reached at a known word count.

// File: rtl/psb_pkg.sv
package psb_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_WAIT,
    S_RD_HOLD,
    S_WR_DATA,
    S_WR_PULSE,
    S_WR_REC
  } psb_state_e;
endpackage

// File: rtl/psb_range_chk.sv
module psb_range_chk #(
  parameter int PAGE_WORDS = 16,
  localparam int PW = $clog2(PAGE_WORDS)
) (
  input  logic [PW-1:0] offset_i,
  input  logic [PW:0]   cnt_i,
  output logic          bad_o
);
  logic [PW+1:0] reach;

  always_comb begin
    reach = {2'b00, offset_i} + {1'b0, cnt_i};
    bad_o = (cnt_i == '0) || (reach > (PW+2)'(PAGE_WORDS));
  end
endmodule

// File: rtl/psb_timer.sv
module psb_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load_i)      cnt <= val_i;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero_o = (cnt == '0);
endmodule

// File: rtl/psb_window.sv
module psb_window #(
  parameter int LIMIT_CYC = 2000,
  parameter int GUARD_CYC = 1978,
  localparam int WW = $clog2(LIMIT_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  output logic near_o
);
  logic [WW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !active_i)                 cnt <= '0;
    else if (cnt != WW'(LIMIT_CYC))       cnt <= cnt + 1'b1;
  end

  assign near_o = (cnt >= WW'(GUARD_CYC));
endmodule

// File: rtl/psb_page_burst.sv
module psb_page_burst
  import psb_pkg::*;
#(
  parameter int AW         = 21,
  parameter int DW         = 16,
  parameter int PAGE_WORDS = 16,
  parameter int FIRST_CYC  = 7,
  parameter int PAGE_CYC   = 3,
  parameter int WP_FIRST   = 5,
  parameter int WP_CYC     = 3,
  parameter int REC_CYC    = 1,
  parameter int LIMIT_CYC  = 2000,
  localparam int PW        = $clog2(PAGE_WORDS),
  localparam int CW        = PW + 1,
  localparam int BW        = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_valid,
  output logic          start_ready,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] start_cnt,
  input  logic          start_write,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic          truncated,
  output logic [CW-1:0] words_done,
  output logic          err,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [BW-1:0] mem_be_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int M1   = (FIRST_CYC > PAGE_CYC) ? FIRST_CYC : PAGE_CYC;
  localparam int M2   = (WP_FIRST > WP_CYC) ? WP_FIRST : WP_CYC;
  localparam int M3   = (M2 > REC_CYC) ? M2 : REC_CYC;
  localparam int TMAX = (M1 > M3) ? M1 : M3;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int SLACK = FIRST_CYC + WP_FIRST + REC_CYC + PAGE_CYC + 4;
  localparam int GUARD = LIMIT_CYC - SLACK;

  psb_state_e    state;
  logic [CW-1:0] burst_cnt;
  logic [CW-1:0] done_cnt;
  logic          range_bad;
  logic          stop;
  logic          tmr_zero;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          last;
  logic          fin_now;
  logic          fin_trunc;

  psb_range_chk #(.PAGE_WORDS(PAGE_WORDS)) u_range (
    .offset_i (start_addr[PW-1:0]),
    .cnt_i    (start_cnt),
    .bad_o    (range_bad)
  );

  psb_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  psb_window #(.LIMIT_CYC(LIMIT_CYC), .GUARD_CYC(GUARD)) u_window (
    .clk      (clk),
    .rst      (rst),
    .active_i (!mem_cs_n),
    .near_o   (stop)
  );

  assign start_ready = (state == S_IDLE);
  assign wr_ready    = (state == S_WR_DATA) && !stop;
  assign last        = ((done_cnt + CW'(1)) == burst_cnt);

  // Wait-timer loads: long wait on the first word, page wait afterwards.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      S_IDLE: if (start_valid && !range_bad && !start_write) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(FIRST_CYC);
      end
      S_RD_HOLD: if (!stop && rd_ready && !last) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(PAGE_CYC);
      end
      S_WR_DATA: if (!stop && wr_valid) begin
        tmr_load = 1'b1;
        tmr_val  = (done_cnt == '0) ? TW'(WP_FIRST) : TW'(WP_CYC);
      end
      S_WR_PULSE: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(REC_CYC);
      end
      default: ;
    endcase
  end

  // Burst end: normal on the last word, early when the window runs short.
  always_comb begin
    fin_trunc = stop && ((state == S_RD_HOLD) || (state == S_WR_DATA));
    fin_now   = fin_trunc
             || ((state == S_RD_HOLD) && rd_ready && last)
             || ((state == S_WR_REC) && tmr_zero && last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      burst_cnt  <= '0;
      done_cnt   <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      done       <= 1'b0;
      truncated  <= 1'b0;
      words_done <= '0;
      err        <= 1'b0;
      mem_addr   <= '0;
      mem_cs_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_be_n   <= '1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        S_IDLE: if (start_valid) begin
          if (range_bad) begin
            err <= 1'b1;
          end else begin
            mem_addr   <= start_addr;
            mem_cs_n   <= 1'b0;
            mem_be_n   <= '0;
            burst_cnt  <= start_cnt;
            done_cnt   <= '0;
            truncated  <= 1'b0;
            words_done <= '0;
            if (start_write) begin
              mem_oe_n <= 1'b1;
              state    <= S_WR_DATA;
            end else begin
              mem_oe_n <= 1'b0;
              state    <= S_RD_WAIT;
            end
          end
        end
        S_RD_WAIT: if (tmr_zero) begin
          rd_data  <= mem_dq_in;
          rd_valid <= 1'b1;
          state    <= S_RD_HOLD;
        end
        S_RD_HOLD: if (!stop && rd_ready) begin
          rd_valid <= 1'b0;
          done_cnt <= done_cnt + 1'b1;
          if (!last) begin
            mem_addr[PW-1:0] <= mem_addr[PW-1:0] + 1'b1;
            state            <= S_RD_WAIT;
          end
        end
        S_WR_DATA: if (!stop && wr_valid) begin
          mem_dq_out <= wr_data;
          mem_dq_oe  <= 1'b1;
          mem_we_n   <= 1'b0;
          state      <= S_WR_PULSE;
        end
        S_WR_PULSE: if (tmr_zero) begin
          mem_we_n <= 1'b1;
          state    <= S_WR_REC;
        end
        S_WR_REC: if (tmr_zero) begin
          done_cnt <= done_cnt + 1'b1;
          if (!last) begin
            mem_addr[PW-1:0] <= mem_addr[PW-1:0] + 1'b1;
            state            <= S_WR_DATA;
          end
        end
        default: state <= S_IDLE;
      endcase

      if (fin_now) begin
        state      <= S_IDLE;
        mem_cs_n   <= 1'b1;
        mem_oe_n   <= 1'b1;
        mem_we_n   <= 1'b1;
        mem_be_n   <= '1;
        mem_dq_oe  <= 1'b0;
        rd_valid   <= 1'b0;
        done       <= 1'b1;
        truncated  <= fin_trunc;
        words_done <= fin_trunc ? done_cnt : burst_cnt;
      end
    end
  end
endmodule

// File: rtl/psb_burst_chk.sv
module psb_burst_chk #(
  parameter int AW        = 21,
  parameter int DW        = 16,
  parameter int PW        = 4,
  parameter int LIMIT_CYC = 2000,
  localparam int BW       = DW / 8
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [DW-1:0] rd_data,
  input logic          done,
  input logic          err,
  input logic [AW-1:0] mem_addr,
  input logic          mem_cs_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic [BW-1:0] mem_be_n,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_dq_oe
);
  int low_run;

  always_ff @(posedge clk) begin
    if (rst || mem_cs_n) low_run <= 0;
    else                 low_run <= low_run + 1;
  end

  assert_err_idle_R2: assert property (@(posedge clk) disable iff (rst)
    err |-> mem_cs_n);

  assert_page_fixed_R3: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(!mem_cs_n)) |-> (mem_addr[AW-1:PW] == $past(mem_addr[AW-1:PW])));

  assert_step_one_R3: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(!mem_cs_n) && (mem_addr != $past(mem_addr)))
      |-> (mem_addr[PW-1:0] == $past(mem_addr[PW-1:0]) + 1'b1));

  assert_bytes_on_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_n |-> (mem_be_n == '0));

  assert_release_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (mem_cs_n && mem_we_n && mem_oe_n));

  assert_rd_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> ((rd_valid && $stable(rd_data)) || done));

  assert_we_in_cs_R7: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_cs_n && mem_dq_oe));

  assert_we_data_R7: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out));

  assert_we_hold_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_out)));

  assert_no_clash_R8: assert property (@(posedge clk) disable iff (rst)
    !(mem_dq_oe && !mem_oe_n));

  assert_window_R9: assert property (@(posedge clk) disable iff (rst)
    low_run < LIMIT_CYC);
endmodule

bind psb_page_burst psb_burst_chk #(
  .AW(AW), .DW(DW), .PW(PW), .LIMIT_CYC(LIMIT_CYC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_data    (rd_data),
  .done       (done),
  .err        (err),
  .mem_addr   (mem_addr),
  .mem_cs_n   (mem_cs_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_be_n   (mem_be_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/psb_page_burst_test.sv
`timescale 1ns/1ps
module psb_page_burst_test;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam int CW = 5;
  localparam int FIRST_CYC = 7;
  localparam int PAGE_CYC  = 3;
  localparam int LIMIT_CYC = 2000;
  localparam logic [15:0] POISON = 16'hBAD0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_valid = 1'b0;
  logic          start_ready;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] start_cnt = '0;
  logic          start_write = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [DW-1:0] wr_data = '0;
  logic          rd_valid;
  logic          rd_ready = 1'b0;
  logic [DW-1:0] rd_data;
  logic          done, truncated, err;
  logic [CW-1:0] words_done;
  logic [AW-1:0] mem_addr;
  logic          mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]    mem_be_n;
  logic [DW-1:0] mem_dq_out, mem_dq_in;

  always #5 clk = ~clk;

  psb_page_burst uut (
    .clk(clk), .rst(rst),
    .start_valid(start_valid), .start_ready(start_ready),
    .start_addr(start_addr), .start_cnt(start_cnt), .start_write(start_write),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .truncated(truncated), .words_done(words_done), .err(err),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // Memory model: poison until the access or page wait has elapsed.
  logic [15:0]   mem   [256];
  logic [15:0]   shadow[256];
  logic [AW-1:0] addr_q;
  logic          cs_q, we_q, fresh;
  int            age;
  int            we_falls;
  int            low_run, low_max;

  always @(posedge clk) begin
    if (we_q && !mem_we_n) we_falls <= we_falls + 1;
    if (!we_q && mem_we_n && !mem_cs_n) mem[mem_addr[7:0]] <= mem_dq_out;
    if (mem_cs_n) begin
      age   <= 0;
      fresh <= 1'b1;
    end else begin
      age <= (mem_addr != addr_q) ? 1 : age + 1;
      if (!cs_q && mem_addr != addr_q) fresh <= 1'b0;
    end
    if (mem_cs_n) low_run <= 0;
    else begin
      low_run <= low_run + 1;
      if (low_run + 1 > low_max) low_max <= low_run + 1;
    end
    addr_q <= mem_addr;
    cs_q   <= mem_cs_n;
    we_q   <= mem_we_n;
  end

  assign mem_dq_in = (!mem_cs_n && !mem_oe_n &&
                      age >= (fresh ? FIRST_CYC : PAGE_CYC)) ? mem[mem_addr[7:0]] : POISON;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_start(input bit wr, input logic [AW-1:0] a, input logic [CW-1:0] n);
    @(negedge clk);
    start_valid = 1'b1; start_write = wr; start_addr = a; start_cnt = n;
    while (!start_ready) @(negedge clk);
    @(posedge clk); #1;
    start_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(done, req, {31'd0, done}, 32'd1);
  endtask

  task automatic write_burst(input logic [AW-1:0] a, input int n, input logic [15:0] seed, input int give);
    int p0 = we_falls;
    do_start(1'b1, a, CW'(n));
    for (int i = 0; i < give; i++) begin
      @(negedge clk);
      wr_valid = 1'b1; wr_data = seed + 16'(i);
      while (!wr_ready) @(negedge clk);
      @(posedge clk); #1;
      wr_valid = 1'b0;
      shadow[(int'(a[7:0]) + i) % 256] = seed + 16'(i);
    end
    wait_done("R9/R10 write done");
    chk(truncated == (give < n), "R9/R10 write truncated", {31'd0, truncated}, {31'd0, give < n});
    chk(int'(words_done) == give, "R9/R10 write words_done", 32'(words_done), 32'(give));
    @(negedge clk);
    chk(we_falls - p0 == give, "R7 one write pulse per word", 32'(we_falls - p0), 32'(give));
    chk(mem_cs_n && mem_be_n == 2'b11, "R4 strobes released", {30'd0, mem_be_n}, 32'd3);
  endtask

  task automatic read_burst(input logic [AW-1:0] a, input int n, input int take);
    do_start(1'b0, a, CW'(n));
    for (int i = 0; i < take; i++) begin
      @(negedge clk);
      while (!rd_valid) @(negedge clk);
      chk(rd_data == shadow[(int'(a[7:0]) + i) % 256], "R5/R6 read word",
          32'(rd_data), 32'(shadow[(int'(a[7:0]) + i) % 256]));
      rd_ready = 1'b1;
      @(posedge clk); #1;
      rd_ready = 1'b0;
    end
    wait_done("R9/R10 read done");
    chk(truncated == (take < n), "R9/R10 read truncated", {31'd0, truncated}, {31'd0, take < n});
    chk(int'(words_done) == take, "R9/R10 read words_done", 32'(words_done), 32'(take));
    chk(!rd_valid, "R6 valid dropped at end", {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic reject(input logic [AW-1:0] a, input logic [CW-1:0] n, input string req);
    do_start(1'b0, a, n);
    @(negedge clk);
    chk(err && mem_cs_n, req, {30'd0, err, mem_cs_n}, 32'd3);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!err && !done && mem_cs_n && mem_oe_n, {req, " quiet"}, {30'd0, err, done}, 32'd0);
    end
  endtask

  // {address, count, seed}
  localparam logic [41:0] VEC [5] = '{
    {21'h0A5C30, 5'd16, 16'h1000},
    {21'h000007, 5'd9,  16'h2200},
    {21'h1FFFFF, 5'd1,  16'h3300},
    {21'h012345, 5'd4,  16'h4400},
    {21'h0ABCD2, 5'd3,  16'h5500}
  };

  initial begin
    repeat (256) begin end
    for (int i = 0; i < 256; i++) begin mem[i] = 16'h0; shadow[i] = 16'h0; end
    we_falls = 0; low_run = 0; low_max = 0; age = 0; fresh = 1'b1;
    addr_q = '0; cs_q = 1'b1; we_q = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_cs_n && mem_oe_n && mem_we_n && mem_be_n == 2'b11, "R1 strobes idle",
        {27'd0, mem_cs_n, mem_oe_n, mem_we_n, mem_be_n}, 32'h1F);
    chk(start_ready && !mem_dq_oe && !rd_valid, "R1 ready, bus released",
        {29'd0, start_ready, mem_dq_oe, rd_valid}, 32'h4);

    for (int v = 0; v < 5; v++) begin
      write_burst(VEC[v][41:21], int'(VEC[v][20:16]), VEC[v][15:0], int'(VEC[v][20:16]));
      read_burst(VEC[v][41:21], int'(VEC[v][20:16]), int'(VEC[v][20:16]));
    end

    reject(21'h00000D, 5'd4, "R2 offset 13 count 4");
    reject(21'h000000, 5'd0, "R2 count zero");
    reject(21'h000000, 5'd17, "R2 count 17");
    reject(21'h00001F, 5'd2, "R2 offset 15 count 2");

    write_burst(21'h000050, 4, 16'h6600, 2);
    read_burst(21'h000050, 2, 2);
    read_burst(21'h0A5C30, 3, 1);

    chk(low_max < LIMIT_CYC, "R9 chip select window", 32'(low_max), 32'(LIMIT_CYC));

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule